// File: doc/BRIEF.md
# Fastlock Timer Current Selector

This block decides which of two stored 3-bit charge-pump current codes is presented to the pump. One code is the normal, low-bandwidth setting used once the loop has settled. The other is a stronger setting used to speed up acquisition. A two-bit mode field selects the rule that applies. With fastlock disabled, the normal code is always used. In the software-held mode, the strong code is used for as long as a software bit stays set. In the timed mode, each divider load starts a countdown of phase-detector cycles, and the strong code is used until that countdown ends.

The timeout is set by a 4-bit field and equals 3 plus 4 times the field value, counted in phase-detector strobes. A field of 0 gives 3 strobes and a field of 15 gives 63. A current code k stands for (k+1)/8 of the maximum pump current, so code 0 is one eighth and code 7 is full scale. The block only passes the code through; the current itself is produced elsewhere.

The control is a three-state machine. ST_NORM drives the normal code. ST_HOLD drives the strong code in the software-held mode. ST_TIMED drives the strong code while the countdown runs. The named transitions are:
- NORM_TO_HOLD and HOLD_TO_NORM, which follow the software bit in the software-held mode.
- ANY_TO_TIMED, taken on a divider load in the timed mode.
- TIMED_RELOAD, which restarts the countdown when a load arrives during a countdown.
- TIMED_EXPIRE, which returns to ST_NORM on the final strobe.
- FORCE_NORM, taken when the mode no longer supports the current state.

Top module: `fastlock_cur_sel`

## Requirements
- R1: The field mode_i has bit 1 as the fastlock enable and bit 0 as the mode select. When the enable bit is 0, fast_active_o is low and cp_code_o equals cur_norm_i from the next clock onward, whatever the other inputs are.
- R2: Mode 2'b01, with the enable clear and the select set, behaves as disabled: sw_fast_i and load_i have no effect and the normal code is driven.
- R3: In mode 2'b10 (software-held), the strong code is driven one clock after sw_fast_i is sampled high. The normal code returns one clock after sw_fast_i is sampled low.
- R4: In mode 2'b11 (timed), a clock with load_i high makes fast_active_o high from the next clock.
- R5: After a load in the timed mode, the strong code stays driven through T = 3 + 4*timer_sel_i strobes of pfd_tick_i, with timer_sel_i sampled at the load. The normal code is driven from the clock after the T-th strobe and stays until the next load.
- R6: Clocks without pfd_tick_i high do not advance the countdown.
- R7: A load during a countdown restarts it from the full timeout. When load and strobe fall in the same clock, the load wins.
- R8: fast_active_o is high exactly when cp_code_o is driven from cur_fast_i; otherwise cp_code_o follows cur_norm_i. Changes to either code field reach cp_code_o in the same cycle.
- R9: While rst_n is low, and after reset, the block is in ST_NORM with fast_active_o low.
- R10: sw_fast_i is ignored in the timed mode, and load_i is ignored in the software-held mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cur_norm_i | input | 3 | Normal current code (setting 1) |
| cur_fast_i | input | 3 | Fast-acquisition current code (setting 2) |
| fl_mode_i | input | 2 | Bit 1 enable, bit 0 mode select (0 software-held, 1 timed) |
| timer_sel_i | input | 4 | Timeout select, T = 3 + 4*value strobes |
| pfd_tick_i | input | 1 | One-clock strobe per phase-detector cycle |
| load_i | input | 1 | One-clock strobe marking a new divider load |
| sw_fast_i | input | 1 | Software fastlock-enable bit |
| cp_code_o | output | 3 | Active charge-pump current code |
| fast_active_o | output | 1 | High while the fast code is driven |

## Verification
The bench builds the block with its default parameters: 3-bit codes, a 4-bit timer field, a base of 3 and a step of 4. With these values, every timeout from 3 up to 63 strobes can be reached within a short run. Directed runs drive the extreme field values 0 and 15 to exactly their last strobe. Random phases keep the strobes sparse so that long countdowns overlap with reloads, stalls and mode changes.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        FL_OFF   = 2'd0,
        FL_HELD  = 2'd1,
        FL_TIMED = 2'd2
    } fl_mode_e;

    typedef enum logic [1:0] {
        ST_NORM  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_TIMED = 2'd2
    } fl_state_e;

endpackage

// File: rtl/fl_mode_decode.sv
module fl_mode_decode
    import fl_pkg::*;
(
    input  logic [1:0] field_i,
    output fl_mode_e   mode_o
);

    // bit 1 enables fastlock, bit 0 picks timed over software-held
    always_comb begin
        unique case (field_i)
            2'b10:   mode_o = FL_HELD;
            2'b11:   mode_o = FL_TIMED;
            default: mode_o = FL_OFF;
        endcase
    end

endmodule

// File: rtl/fl_timeout_ctr.sv
module fl_timeout_ctr #(
    parameter int TC_W    = 4,
    parameter int TO_BASE = 3,
    parameter int TO_STEP = 4,
    parameter int CNT_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            tick_i,
    input  logic            run_i,
    input  logic [TC_W-1:0] tc_sel_i,
    output logic            expire_o
);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(TO_BASE) + CNT_W'(TO_STEP) * CNT_W'(tc_sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_i) begin
            remain_q <= load_val;
        end else if (run_i && tick_i && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expire_o = run_i && tick_i && !start_i && (remain_q <= CNT_W'(1));

endmodule

// File: rtl/fl_code_sel.sv
module fl_code_sel #(
    parameter int CODE_W = 3
) (
    input  logic              pick_fast_i,
    input  logic [CODE_W-1:0] norm_i,
    input  logic [CODE_W-1:0] fast_i,
    output logic [CODE_W-1:0] code_o
);

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign code_o[b] = pick_fast_i ? fast_i[b] : norm_i[b];
    end

endmodule

// File: rtl/fastlock_cur_sel.sv
module fastlock_cur_sel
    import fl_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int TC_W    = 4,
    parameter int TO_BASE = 3,
    parameter int TO_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cur_norm_i,
    input  logic [CODE_W-1:0] cur_fast_i,
    input  logic [1:0]        fl_mode_i,
    input  logic [TC_W-1:0]   timer_sel_i,
    input  logic              pfd_tick_i,
    input  logic              load_i,
    input  logic              sw_fast_i,
    output logic [CODE_W-1:0] cp_code_o,
    output logic              fast_active_o
);

    localparam int MAX_TO = TO_BASE + TO_STEP * ((1 << TC_W) - 1);
    localparam int CNT_W  = $clog2(MAX_TO + 1);

    fl_mode_e  mode;
    fl_state_e state_q;
    fl_state_e state_d;
    logic      start_cnt;
    logic      expire;
    logic      pick_fast;

    fl_mode_decode u_dec (
        .field_i (fl_mode_i),
        .mode_o  (mode)
    );

    assign start_cnt = (mode == FL_TIMED) && load_i;

    fl_timeout_ctr #(
        .TC_W    (TC_W),
        .TO_BASE (TO_BASE),
        .TO_STEP (TO_STEP),
        .CNT_W   (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_cnt),
        .tick_i   (pfd_tick_i),
        .run_i    (state_q == ST_TIMED),
        .tc_sel_i (timer_sel_i),
        .expire_o (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORM: begin
                if (mode == FL_HELD && sw_fast_i)   state_d = ST_HOLD;   // NORM_TO_HOLD
                else if (start_cnt)                 state_d = ST_TIMED;  // ANY_TO_TIMED
            end
            ST_HOLD: begin
                if (start_cnt)                      state_d = ST_TIMED;  // ANY_TO_TIMED
                else if (mode != FL_HELD)           state_d = ST_NORM;   // FORCE_NORM
                else if (!sw_fast_i)                state_d = ST_NORM;   // HOLD_TO_NORM
            end
            ST_TIMED: begin
                if (start_cnt)                      state_d = ST_TIMED;  // TIMED_RELOAD
                else if (mode == FL_HELD)           state_d = sw_fast_i ? ST_HOLD : ST_NORM;
                else if (mode == FL_OFF)            state_d = ST_NORM;   // FORCE_NORM
                else if (expire)                    state_d = ST_NORM;   // TIMED_EXPIRE
            end
            default:                                state_d = ST_NORM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORM;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pick_fast     = (state_q == ST_HOLD) || (state_q == ST_TIMED);
        fast_active_o = pick_fast;
    end

    fl_code_sel #(
        .CODE_W (CODE_W)
    ) u_mux (
        .pick_fast_i (pick_fast),
        .norm_i      (cur_norm_i),
        .fast_i      (cur_fast_i),
        .code_o      (cp_code_o)
    );

endmodule

// File: rtl/fl_sel_chk.sv
module fl_sel_chk #(
    parameter int CODE_W  = 3,
    parameter int TC_W    = 4,
    parameter int TO_BASE = 3,
    parameter int TO_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] cur_norm_i,
    input logic [CODE_W-1:0] cur_fast_i,
    input logic [1:0]        fl_mode_i,
    input logic [TC_W-1:0]   timer_sel_i,
    input logic              pfd_tick_i,
    input logic              load_i,
    input logic              sw_fast_i,
    input logic [CODE_W-1:0] cp_code_o,
    input logic              fast_active_o
);

    localparam int LIM_W = $clog2(TO_BASE + TO_STEP * ((1 << TC_W) - 1) + 1) + 1;

    logic             armed;
    logic [LIM_W-1:0] seen;
    logic [LIM_W-1:0] lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            seen  <= '0;
            lim   <= '0;
        end else if (fl_mode_i == 2'b11 && load_i) begin
            armed <= 1'b1;
            seen  <= '0;
            lim   <= LIM_W'(TO_BASE) + LIM_W'(TO_STEP) * LIM_W'(timer_sel_i);
        end else if (fl_mode_i != 2'b11 || !fast_active_o) begin
            armed <= 1'b0;
        end else if (pfd_tick_i && armed) begin
            seen <= seen + 1'b1;
        end
    end

    // R1
    off_forces_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_mode_i[1] |=> !fast_active_o);

    // R3
    held_follows_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode_i == 2'b10) |=> (fast_active_o == $past(sw_fast_i)));

    // R4
    load_goes_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode_i == 2'b11 && load_i) |=> fast_active_o);

    // R5
    timed_no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode_i == 2'b11 && !load_i && !fast_active_o) |=> !fast_active_o);

    // R5
    timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fast_active_o) |-> (seen < lim));

    // R8
    code_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_active_o |-> (cp_code_o == cur_fast_i));

    // R8
    code_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_active_o |-> (cp_code_o == cur_norm_i));

endmodule

bind fastlock_cur_sel fl_sel_chk #(
    .CODE_W  (CODE_W),
    .TC_W    (TC_W),
    .TO_BASE (TO_BASE),
    .TO_STEP (TO_STEP)
) u_chk (.*);

// File: tb/fastlock_cur_sel_tb.sv
`timescale 1ns/1ps
module fastlock_cur_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cur_norm_i = '0;
    logic [2:0] cur_fast_i = '0;
    logic [1:0] fl_mode_i = '0;
    logic [3:0] timer_sel_i = '0;
    logic       pfd_tick_i = 1'b0;
    logic       load_i = 1'b0;
    logic       sw_fast_i = 1'b0;
    logic [2:0] cp_code_o;
    logic       fast_active_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    bit m_fast = 1'b0;
    bit m_timed = 1'b0;
    int m_left = 0;

    always #2 clk = ~clk;

    fastlock_cur_sel u_dut (.*);

    function automatic int timeout_of(input logic [3:0] tc);
        return 3 + 4 * int'(tc);
    endfunction

    function automatic logic [2:0] exp_code(input bit fast, input logic [2:0] nrm, input logic [2:0] fst);
        return fast ? fst : nrm;
    endfunction

    task automatic model_step();
        if (!fl_mode_i[1]) begin
            m_fast = 1'b0; m_timed = 1'b0;
        end else if (!fl_mode_i[0]) begin
            m_fast = sw_fast_i; m_timed = 1'b0;
        end else if (load_i) begin
            m_fast = 1'b1; m_timed = 1'b1; m_left = timeout_of(timer_sel_i);
        end else if (m_timed) begin
            if (pfd_tick_i) begin
                if (m_left <= 1) begin m_fast = 1'b0; m_timed = 1'b0; end
                else m_left = m_left - 1;
            end
        end else begin
            m_fast = 1'b0;
        end
    endtask

    task automatic check(input string tag);
        logic [2:0] ec;
        ec = exp_code(m_fast, cur_norm_i, cur_fast_i);
        n_chk++;
        if (fast_active_o !== m_fast || cp_code_o !== ec) begin
            n_bad++;
            $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d",
                     tag, fast_active_o, cp_code_o, m_fast, ec);
        end
    endtask

    // one clock: inputs already set at negedge, model follows the edge, compare after
    task automatic cycle(input string tag);
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic tick_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pfd_tick_i = 1'b1; cycle(tag);
            pfd_tick_i = 1'b0; cycle(tag);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        cur_norm_i = 3'd2; cur_fast_i = 3'd6;
        fl_mode_i = 2'b11; load_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9");
        load_i = 1'b0;
        rst_n = 1'b1;
        cycle("R9");

        // R1: disabled with sw and load active
        fl_mode_i = 2'b00; sw_fast_i = 1'b1; load_i = 1'b1;
        cycle("R1");
        // R2: 01 behaves as disabled
        fl_mode_i = 2'b01;
        cycle("R2"); cycle("R2");
        load_i = 1'b0;

        // R3: software-held
        fl_mode_i = 2'b10; sw_fast_i = 1'b1;
        cycle("R3");
        cur_fast_i = 3'd7; #1; check("R8");
        sw_fast_i = 1'b0;
        cycle("R3");
        // R10: load ignored in held mode
        load_i = 1'b1; cycle("R10"); load_i = 1'b0; cycle("R10");

        // R4/R5: TC=0 gives 3 strobes
        fl_mode_i = 2'b11; timer_sel_i = 4'd0; load_i = 1'b1;
        cycle("R4"); load_i = 1'b0;
        tick_n(2, "R5");
        repeat (10) cycle("R6");
        tick_n(1, "R5");
        repeat (5) cycle("R5");

        // R10: sw ignored in timed mode
        sw_fast_i = 1'b1; repeat (3) cycle("R10"); sw_fast_i = 1'b0;

        // R5: TC=15 gives 63 strobes
        timer_sel_i = 4'd15; load_i = 1'b1; cycle("R4"); load_i = 1'b0;
        tick_n(62, "R5");
        tick_n(1, "R5");

        // R7: reload restarts, load beats tick
        timer_sel_i = 4'd1; load_i = 1'b1; cycle("R4"); load_i = 1'b0;
        tick_n(5, "R7");
        load_i = 1'b1; pfd_tick_i = 1'b1; cycle("R7");
        load_i = 1'b0; pfd_tick_i = 1'b0;
        tick_n(6, "R7");
        tick_n(1, "R7");
        repeat (3) cycle("R7");

        // random phase
        for (int i = 0; i < 20000; i++) begin
            string tag;
            cur_norm_i = 3'($urandom);
            cur_fast_i = 3'($urandom);
            if ($urandom_range(0, 99) == 0) fl_mode_i = 2'($urandom);
            if ($urandom_range(0, 19) == 0) sw_fast_i = ~sw_fast_i;
            if ($urandom_range(0, 7) == 0) timer_sel_i = 4'($urandom);
            load_i = ($urandom_range(0, 79) == 0);
            pfd_tick_i = ($urandom_range(0, 2) == 0);
            case (fl_mode_i)
                2'b10:   tag = "R3";
                2'b11:   tag = "R5";
                default: tag = "R1";
            endcase
            cycle(tag);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule